// File: doc/BRIEF.md
# I2C Crossbar Routing Register

This block is a write-only I2C slave that holds the routing choices of an eight-source, six-sink video crossbar. It samples the bus lines with the system clock and finds START and STOP conditions. It checks the address byte, which depends on a strap input. It then turns each command byte that follows into an update of one sink's 3-bit source selector. The six selectors leave the block as one flat bus that feeds the analog switch fabric.

A host changes one route per command byte. Rebuilding the whole map therefore takes six commands. These may be sent as six separate transactions or as a run of bytes inside one transaction. The strap input lets two of these blocks share one bus and still be addressed apart.

Top module: `xbar_route_i2c`

## Requirements
- R1: After reset every selector reads source 0, SDA is released (`sda_oe` = 0), and the slave waits for a START.
- R2: With `addr_strap` low, the slave ACKs the address byte 0x86 (8 bits, write bit included). With `addr_strap` high, it ACKs 0x06.
- R3: An address byte that does not match, including the other strap's address or any byte with the read bit (bit 0) set, gets no ACK. Bytes after it change no selector until the next START.
- R4: A command byte sets the selector of sink `byte[5:3]` to source `byte[2:0]` and is ACKed. For example 0x25 sets sink 4 to source 5. No selector changes without a command.
- R5: A command whose sink field is 6 or 7 is ACKed and leaves all six selectors unchanged.
- R6: Selectors are independent. One source may feed several sinks at the same time.
- R7: Several command bytes in one transaction are each applied, in order.
- R8: A repeated START restarts address reception, whether or not the earlier address matched.
- R9: The ACK drives SDA low from the SCL fall after the eighth bit until the SCL fall after the ninth clock. SDA changing up to 340 ns after an SCL fall causes no false condition.
- R10: A STOP releases SDA and returns the slave to idle. Bytes clocked after it without a START get no ACK and have no effect.
- R11: Command bits [7:6] do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Address select: low gives 0x86, high gives 0x06 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain ACK) |
| sel_o | output | 18 | Six 3-bit source selectors, sink k at bits [3k+2:3k] |

## Verification
A wrong state in the byte engine first shows on `sda_oe`. A missed or extra bit moves the ACK by one SCL period, or drops it. This is visible within the same byte, at its ninth clock. A bad decode or a bad write enable shows on `sel_o` a few system clocks after the eighth SCL rise of the command. It appears either as a wrong sink changing or as a sink that should have held changing. The scoreboard compares the full 18-bit selector bus after every transaction, so a side effect on any sink is caught at once.

// File: rtl/xbar_route_pkg.sv
package xbar_route_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKWAIT,
    ST_ACK,
    ST_SKIP
  } rx_state_e;

  // True when a full 8-bit address byte (write bit included) selects this slave.
  function automatic logic addr_match(input logic [7:0] b, input logic strap,
                                      input logic [6:0] a_lo, input logic [6:0] a_hi);
    return b == {(strap ? a_hi : a_lo), 1'b0};
  endfunction

  // Sink index carried in a command byte.
  function automatic logic [2:0] cmd_sink(input logic [5:0] b);
    return b[5:3];
  endfunction

  // Source index carried in a command byte.
  function automatic logic [2:0] cmd_src(input logic [5:0] b);
    return b[2:0];
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import xbar_route_pkg::*;
#(
  parameter logic [6:0] ADDR_LO = 7'h43,
  parameter logic [6:0] ADDR_HI = 7'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       strap,
  output logic       sda_oe,
  output logic [7:0] rx_byte,
  output logic       cmd_fire,
  output logic       addr_miss
);
  rx_state_e  st;
  logic [2:0] cnt;
  logic [6:0] sh;
  logic       is_addr;
  logic       byte_done, hit;

  assign rx_byte   = {sh, sda_s};
  assign byte_done = (st == ST_RX) && scl_rise && (cnt == 3'd7);
  assign hit       = addr_match(rx_byte, strap, ADDR_LO, ADDR_HI);
  assign cmd_fire  = byte_done && !is_addr;
  assign addr_miss = byte_done && is_addr && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      is_addr <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      st      <= ST_RX;
      cnt     <= '0;
      is_addr <= 1'b1;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX: if (scl_rise) begin
          sh  <= rx_byte[6:0];
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) st <= (is_addr && !hit) ? ST_SKIP : ST_ACKWAIT;
        end
        ST_ACKWAIT: if (scl_fall) begin
          sda_oe <= 1'b1;
          st     <= ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          sda_oe  <= 1'b0;
          st      <= ST_RX;
          cnt     <= '0;
          is_addr <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/route_regs.sv
module route_regs
  import xbar_route_pkg::*;
#(
  parameter int NUM_OUT = 6,
  parameter int SEL_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_fire,
  input  logic [5:0]               cmd_byte,
  output logic [NUM_OUT*SEL_W-1:0] sel_o
);
  logic [2:0] sink;
  logic [2:0] src;

  assign sink = cmd_sink(cmd_byte);
  assign src  = cmd_src(cmd_byte);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              sel_o[g*SEL_W +: SEL_W] <= '0;
      else if (cmd_fire && (sink == 3'(g)))    sel_o[g*SEL_W +: SEL_W] <= src[SEL_W-1:0];
    end
  end
endmodule

// File: rtl/xbar_route_i2c.sv
module xbar_route_i2c #(
  parameter int         NUM_IN  = 8,
  parameter int         NUM_OUT = 6,
  parameter logic [6:0] ADDR_LO = 7'h43,
  parameter logic [6:0] ADDR_HI = 7'h03,
  localparam int        SEL_W   = $clog2(NUM_IN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic                     addr_strap,
  output logic                     sda_oe,
  output logic [NUM_OUT*SEL_W-1:0] sel_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rx_byte;
  logic       cmd_fire, addr_miss;

  i2c_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_rx #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_rx (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(addr_strap), .sda_oe(sda_oe), .rx_byte(rx_byte),
    .cmd_fire(cmd_fire), .addr_miss(addr_miss)
  );

  route_regs #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire),
    .cmd_byte(rx_byte[5:0]), .sel_o(sel_o)
  );
endmodule

// File: rtl/xbar_route_chk.sv
module xbar_route_chk #(
  parameter int NUM_OUT = 6,
  parameter int SEL_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     scl_s,
  input logic                     sda_oe,
  input logic                     cmd_fire,
  input logic                     addr_miss,
  input logic                     stop_det,
  input logic [7:0]               cmd_byte,
  input logic [NUM_OUT*SEL_W-1:0] sel_o
);
  // R9: the ACK pull-down only starts while SCL is low
  p_ack_low_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R4: selectors hold when no command completes
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_fire |=> $stable(sel_o));

  // R5: unused sink codes leave every selector alone
  p_unused_sink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && (cmd_byte[5:3] >= 3'(NUM_OUT))) |=> $stable(sel_o));

  // R3: a rejected address is never acknowledged
  p_nack_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe);

  // R10: STOP releases the data line
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_apply
    // R4: the addressed sink takes the commanded source
    p_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && (cmd_byte[5:3] == 3'(g))) |=>
        (sel_o[g*SEL_W +: SEL_W] == $past(cmd_byte[SEL_W-1:0])));
  end
endmodule

bind xbar_route_i2c xbar_route_chk #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .cmd_fire(cmd_fire), .addr_miss(addr_miss), .stop_det(stop_det),
  .cmd_byte(rx_byte), .sel_o(sel_o)
);

// File: tb/xbar_route_i2c_bench.sv
module xbar_route_i2c_bench;
  localparam int Q = 40;      // quarter of an SCL period in system clocks
  localparam int HOLD = 17;   // 340 ns data hold after SCL falls

  typedef struct {
    logic [17:0] sel;
    string       req;
  } exp_item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe;
  logic [17:0] sel_o;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [2:0] model [6];
  exp_item_t q[$];

  always #10 clk = ~clk;

  xbar_route_i2c u_xbar_route_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(strap), .sda_oe(sda_oe), .sel_o(sel_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wait_n(HOLD); sda_m = 1'b1; wait_n(Q); scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(HOLD); sda_m = 1'b0; wait_n(Q); scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b1; wait_n(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit acked;
    for (int i = 7; i >= 0; i--) begin
      wait_n(HOLD); sda_m = b[i]; wait_n(Q - HOLD);
      scl_m = 1'b1; wait_n(Q); scl_m = 1'b0;
    end
    wait_n(HOLD); sda_m = 1'b1; wait_n(Q - HOLD);
    if (exp_ack) check(sda_oe == 1'b1, "R9 ack driven before ninth rise", 32'(sda_oe), 1);
    scl_m = 1'b1; wait_n(Q / 2);
    acked = (sda_line == 1'b0);
    check(acked == exp_ack, req, 32'(acked), 32'(exp_ack));
    wait_n(Q / 2); scl_m = 1'b0; wait_n(Q / 2);
    if (exp_ack) check(sda_oe == 1'b0, "R9 ack released after ninth fall", 32'(sda_oe), 0);
  endtask

  // model of a command byte, written from the requirements
  task automatic model_cmd(input logic [7:0] b);
    if (b[5:3] < 3'd6) model[b[5:3]] = b[2:0];
  endtask

  task automatic push(input string req);
    exp_item_t it;
    for (int k = 0; k < 6; k++) it.sel[k*3 +: 3] = model[k];
    it.req = req;
    q.push_back(it);
  endtask

  task automatic cmd(input logic [7:0] b, input string req);
    send_byte(b, 1'b1, req);
    model_cmd(b);
  endtask

  // monitor: compares the selector bus against each expected item
  initial begin
    forever begin
      wait (q.size() != 0);
      @(negedge clk);
      begin
        exp_item_t it;
        it = q.pop_front();
        check(sel_o === it.sel, it.req, 32'(sel_o), 32'(it.sel));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) model[k] = 3'd0;
    wait_n(5);
    check(sel_o == 18'd0, "R1 selectors clear in reset", 32'(sel_o), 0);
    check(sda_oe == 1'b0, "R1 sda released in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    wait_n(5);
    push("R1 reset state");

    // R2 + R4: strap low, example command
    strap = 1'b0;
    bus_start(); send_byte(8'h86, 1'b1, "R2 address 0x86 acked");
    cmd(8'h25, "R4 command acked"); bus_stop(); push("R4 0x25 sink4=src5");

    // R5: unused sink codes
    bus_start(); send_byte(8'h86, 1'b1, "R2 address ack");
    cmd(8'h33, "R5 sink 6 acked"); cmd(8'h3F, "R5 sink 7 acked");
    bus_stop(); push("R5 no change");

    // R6 + R7: many commands in one transaction, shared source
    bus_start(); send_byte(8'h86, 1'b1, "R2 address ack");
    cmd(8'h07, "R7 cmd"); cmd(8'h0F, "R6 cmd"); cmd(8'h13, "R7 cmd");
    cmd(8'h19, "R7 cmd"); cmd(8'h2C, "R7 cmd");
    bus_stop(); push("R6 R7 multi route");

    // R11: top bits ignored
    bus_start(); send_byte(8'h86, 1'b1, "R2 address ack");
    cmd(8'hC2, "R11 cmd acked"); bus_stop(); push("R11 sink0=src2");

    // R3: wrong address and read bit
    bus_start(); send_byte(8'h06, 1'b0, "R3 other strap address nacked");
    send_byte(8'h0D, 1'b0, "R3 byte after miss ignored"); bus_stop(); push("R3 no change after miss");
    bus_start(); send_byte(8'h87, 1'b0, "R3 read bit nacked");
    send_byte(8'h0D, 1'b0, "R3 byte after read ignored"); bus_stop(); push("R3 no change after read");

    // R2 strap high
    strap = 1'b1;
    bus_start(); send_byte(8'h86, 1'b0, "R3 0x86 nacked with strap high"); bus_stop();
    bus_start(); send_byte(8'h06, 1'b1, "R2 address 0x06 acked");
    cmd(8'h01, "R4 cmd"); bus_stop(); push("R2 strap high route");

    // R8: repeated START after a hit and after a miss
    bus_start(); send_byte(8'h06, 1'b1, "R8 first address");
    cmd(8'h0A, "R8 cmd"); bus_start();
    send_byte(8'h06, 1'b1, "R8 address after repeated start");
    cmd(8'h2B, "R8 cmd"); bus_stop(); push("R8 repeated start hit");
    bus_start(); send_byte(8'h86, 1'b0, "R8 miss first");
    bus_start(); send_byte(8'h06, 1'b1, "R8 address after miss");
    cmd(8'h26, "R8 cmd"); bus_stop(); push("R8 repeated start after miss");

    // R10: bytes without START after STOP
    wait_n(Q); scl_m = 1'b0; wait_n(Q);
    send_byte(8'h06, 1'b0, "R10 no ack without start");
    send_byte(8'h1F, 1'b0, "R10 byte ignored"); bus_stop(); push("R10 no change");

    wait (q.size() == 0);
    wait_n(4);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule